// File: doc/BRIEF.md
# Dual Programmable Clock Divider

This block derives two independent clocks, A and B, from one input clock. The ratio of each is set by a configuration word with a fixed offset. Output A divides by its word plus 2. Output B divides by its word plus 8, and that sum is then multiplied by a factor picked with a 3-bit select code.

The configuration inputs are static straps that may also be changed while the block runs. A channel takes a new setting only at the end of the output period in progress, so a change never shortens a pulse. Words outside the legal range are refused: the channel keeps its last legal ratio and a sticky error flag is raised. Each output is high for the first floor(N/2) input cycles of its N-cycle period.

Reset is asynchronous and active-low, with a synchronous release. It loads the ratios that all-ones words give, which is what the configuration pins read when they are left undriven.

Top module: `dual_clk_divider`

## Requirements
- R1: Output A has a period of exactly a_word + 2 input cycles for every legal a_word from 1 to 127.
- R2: Output B has a period of exactly (b_word + 8) * F input cycles for every legal b_word from 4 to 511. F comes from post_sel as follows: 3'b000 gives 2, 3'b001 gives 4, 3'b010 gives 8, 3'b011 gives 16, 3'b100 gives 32, 3'b101 gives 64, 3'b110 gives 1 and 3'b111 gives 3.
- R3: In each period of N cycles an output is high for the first floor(N/2) cycles and low for the rest, and it rises only at the start of a period.
- R4: An a_word of 0 is refused, and output A keeps its last legal period.
- R5: A b_word of 0, 1, 2 or 3 is refused, and output B keeps its last legal period.
- R6: cfg_err goes to 1 at the first clock edge at which an illegal a_word or b_word is present. It stays at 1 until reset and is never set while both words are legal.
- R7: A setting change takes effect only when the current period ends. The period in progress completes at its old length, and the next period uses the new setting.
- R8: While reset is asserted, clk_a and clk_b are 1 and cfg_err is 0. After reset the active ratios are 129 for A and 1557 for B (the all-ones settings) until a legal word is loaded at the end of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_word | input | 7 | Divider word for output A (ratio = word + 2) |
| b_word | input | 9 | Divider word for output B (ratio = (word + 8) * factor) |
| post_sel | input | 3 | Post-divider factor select for output B |
| clk_a | output | 1 | Divided clock A |
| clk_b | output | 1 | Divided clock B |
| cfg_err | output | 1 | Sticky flag: an illegal word was presented |

## Verification
The bench builds the block with its default parameters: 7-bit and 9-bit words, offsets of 2 and 8, and minimum words of 1 and 4. These bring the extreme legal words 1, 127, 4 and 511 within reach, along with every post-divider code and the forbidden values just below each minimum. The bench measures periods and high times only at the output pins. The post-reset ratios of 129 and 1557 are observed directly. The largest ratio, 33216, lies within the counter width but is not measured.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_FAC = 64;

  function automatic int unsigned post_factor(input logic [SEL_W-1:0] sel);
    case (sel)
      3'b000:  return 2;
      3'b001:  return 4;
      3'b010:  return 8;
      3'b011:  return 16;
      3'b100:  return 32;
      3'b101:  return 64;
      3'b110:  return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/word_decode.sv
module word_decode
  import dual_div_pkg::*;
#(
  parameter int W        = 7,
  parameter int OFS      = 2,
  parameter int MINW     = 1,
  parameter int RW       = 8,
  parameter bit USE_POST = 1'b0
) (
  input  logic [W-1:0]     word,
  input  logic [SEL_W-1:0] sel,
  output logic [RW-1:0]    ratio,
  output logic             legal
);
  int unsigned fac;
  int unsigned base;

  always_comb begin
    fac   = USE_POST ? post_factor(sel) : 32'd1;
    base  = 32'(word) + 32'(OFS);
    ratio = RW'(base * fac);
    legal = (32'(word) >= 32'(MINW));
  end
endmodule

// File: rtl/div_chan.sv
module div_chan #(
  parameter int          RW        = 8,
  parameter int unsigned DEF_RATIO = 129,
  parameter int unsigned MIN_RATIO = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] req_ratio,
  input  logic          req_ok,
  output logic          clk_out
);
  localparam logic [RW-1:0] DEF_R = RW'(DEF_RATIO);
  localparam logic [RW-1:0] MIN_R = RW'(MIN_RATIO);

  logic [RW-1:0] cnt_q, cnt_d, ratio_q, ratio_d;
  logic          hi_q, hi_d, term;

  assign term = (cnt_q == ratio_q - 1'b1);

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    ratio_d = ratio_q;
    if (term) begin
      cnt_d = '0;
      if (req_ok) ratio_d = req_ratio;
    end
    hi_d = (cnt_d < (ratio_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= DEF_R;
      hi_q    <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      hi_q    <= hi_d;
    end
  end

  assign clk_out = hi_q;

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);                                       // R1
  AST_RATIO_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(ratio_q));                            // R7
  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= MIN_R);                                      // R4
  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> (cnt_q == '0));                         // R3
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
  import dual_div_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int B_W   = 9,
  parameter int A_OFS = 2,
  parameter int B_OFS = 8,
  parameter int A_MIN = 1,
  parameter int B_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   a_word,
  input  logic [B_W-1:0]   b_word,
  input  logic [SEL_W-1:0] post_sel,
  output logic             clk_a,
  output logic             clk_b,
  output logic             cfg_err
);
  localparam int unsigned A_MAXR = (2**A_W - 1) + A_OFS;
  localparam int unsigned B_BASE = (2**B_W - 1) + B_OFS;
  localparam int unsigned B_MAXR = B_BASE * MAX_FAC;
  localparam int          A_RW   = $clog2(A_MAXR + 1);
  localparam int          B_RW   = $clog2(B_MAXR + 1);
  localparam int unsigned A_DEF  = A_MAXR;
  localparam int unsigned B_DEF  = B_BASE * post_factor('1);
  localparam int unsigned A_MINR = A_MIN + A_OFS;
  localparam int unsigned B_MINR = B_MIN + B_OFS;

  logic            rst_n_s;
  logic [A_RW-1:0] a_ratio;
  logic [B_RW-1:0] b_ratio;
  logic            a_legal, b_legal;
  logic            err_q, err_d;

  rst_sync i_rst_sync (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  word_decode #(.W(A_W), .OFS(A_OFS), .MINW(A_MIN), .RW(A_RW), .USE_POST(1'b0)) i_dec_a (
    .word(a_word), .sel(post_sel), .ratio(a_ratio), .legal(a_legal));

  word_decode #(.W(B_W), .OFS(B_OFS), .MINW(B_MIN), .RW(B_RW), .USE_POST(1'b1)) i_dec_b (
    .word(b_word), .sel(post_sel), .ratio(b_ratio), .legal(b_legal));

  div_chan #(.RW(A_RW), .DEF_RATIO(A_DEF), .MIN_RATIO(A_MINR)) i_chan_a (
    .clk(clk), .rst_n(rst_n_s), .req_ratio(a_ratio), .req_ok(a_legal), .clk_out(clk_a));

  div_chan #(.RW(B_RW), .DEF_RATIO(B_DEF), .MIN_RATIO(B_MINR)) i_chan_b (
    .clk(clk), .rst_n(rst_n_s), .req_ratio(b_ratio), .req_ok(b_legal), .clk_out(clk_b));

  always_comb begin
    err_d = err_q | ~a_legal | ~b_legal;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign cfg_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_err |=> cfg_err);                                   // R6
  AST_ERR_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!a_legal || !b_legal) |=> cfg_err);                    // R6
endmodule

// File: tb/test_dual_clk_divider.sv
`timescale 1ns/1ps
module test_dual_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] a_word;
  logic [8:0] b_word;
  logic [2:0] post_sel;
  logic       clk_a, clk_b, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_clk_divider i_dual_clk_divider (
    .clk(clk), .rst_n(rst_n), .a_word(a_word), .b_word(b_word),
    .post_sel(post_sel), .clk_a(clk_a), .clk_b(clk_b), .cfg_err(cfg_err));

  // a_word, b_word, post_sel, expected A period, expected B period
  typedef struct packed {
    logic [6:0]  a;
    logic [8:0]  b;
    logic [2:0]  s;
    logic [15:0] ea;
    logic [15:0] eb;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{7'd59,  9'd276, 3'b110, 16'd61,  16'd284},
    '{7'd1,   9'd4,   3'b000, 16'd3,   16'd24},
    '{7'd127, 9'd4,   3'b111, 16'd129, 16'd36},
    '{7'd2,   9'd5,   3'b001, 16'd4,   16'd52},
    '{7'd10,  9'd4,   3'b010, 16'd12,  16'd96},
    '{7'd3,   9'd8,   3'b011, 16'd5,   16'd256},
    '{7'd64,  9'd4,   3'b100, 16'd66,  16'd384},
    '{7'd6,   9'd4,   3'b101, 16'd8,   16'd768},
    '{7'd5,   9'd511, 3'b110, 16'd7,   16'd519}
  };

  function automatic logic sig(input int w);
    return (w != 0) ? clk_b : clk_a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(input int w);
    logic last;
    last = sig(w);
    forever begin
      @(negedge clk);
      if (sig(w) && !last) break;
      last = sig(w);
    end
  endtask

  // Called at the negedge where a rise was seen; returns at the next rise.
  task automatic count_period(input int w, input int apply_at, input logic [6:0] new_a,
                              output int p, output int h);
    logic last;
    p = 1; h = 1; last = 1'b1;
    forever begin
      if (p == apply_at) a_word = new_a;
      @(negedge clk);
      if (sig(w) && !last) break;
      if (sig(w)) h++;
      p++;
      last = sig(w);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 clk_a in reset", int'(clk_a), 1);
    chk("R8 clk_b in reset", int'(clk_b), 1);
    chk("R8 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, h;
    a_word = '1; b_word = '1; post_sel = '1;
    do_reset();
    chk("R6 no error with legal words", int'(cfg_err), 0);

    // R1 R2 R3: table walk
    foreach (VECS[i]) begin
      a_word = VECS[i].a; b_word = VECS[i].b; post_sel = VECS[i].s;
      wait_rise(0);
      count_period(0, -1, 7'd0, p, h);
      chk("R1 A period", p, int'(VECS[i].ea));
      chk("R3 A high time", h, int'(VECS[i].ea) / 2);
      wait_rise(1);
      count_period(1, -1, 7'd0, p, h);
      chk("R2 B period", p, int'(VECS[i].eb));
      chk("R3 B high time", h, int'(VECS[i].eb) / 2);
    end
    chk("R6 error stays low over legal table", int'(cfg_err), 0);

    // R7: change mid-period, old period completes
    a_word = 7'd59;
    wait_rise(0);
    count_period(0, -1, 7'd0, p, h);
    count_period(0, 5, 7'd1, p, h);
    chk("R7 period in progress keeps old length", p, 61);
    count_period(0, -1, 7'd0, p, h);
    chk("R7 next period uses new setting", p, 3);

    // R4, R6: illegal A word
    a_word = 7'd59;
    wait_rise(0);
    count_period(0, -1, 7'd0, p, h);
    a_word = 7'd0;
    @(negedge clk);
    chk("R6 error set after illegal A", int'(cfg_err), 1);
    wait_rise(0);
    count_period(0, -1, 7'd0, p, h);
    chk("R4 A keeps last legal period", p, 61);
    a_word = 7'd1;
    repeat (3) @(negedge clk);
    chk("R6 error sticky after legal word", int'(cfg_err), 1);

    // R8: reset with illegal words keeps defaults
    a_word = 7'd0; b_word = 9'd0; post_sel = 3'b000;
    do_reset();
    chk("R6 error set after reset with illegal words", int'(cfg_err), 1);
    wait_rise(0);
    count_period(0, -1, 7'd0, p, h);
    chk("R8 A default period", p, 129);
    wait_rise(1);
    count_period(1, -1, 7'd0, p, h);
    chk("R8 B default period", p, 1557);

    // R5: illegal B word holds last legal ratio
    a_word = 7'd1; b_word = 9'd4; post_sel = 3'b000;
    wait_rise(1);
    count_period(1, -1, 7'd0, p, h);
    chk("R5 B legal before", p, 24);
    b_word = 9'd3;
    wait_rise(1);
    count_period(1, -1, 7'd0, p, h);
    chk("R5 B keeps last legal period", p, 24);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule